// File: doc/BRIEF.md
# Selectable-Ratio Interval Timer

This block produces a periodic one-cycle tick whose period is a chosen multiple of a selected time base. A 4-bit control word sets the ratio with a 3-bit select field. The ratios form an uneven ladder: 2, 4, 8, 16 and 32, then 256, 2048 and 16384. The top bit of the written word asks for a restart. A restart clears the internal 14-bit count and the time-base prescaler, so the next tick lands a full period after the write. An external permission input can block any restart. When it is low, a write only updates the stored word and the count runs on.

The time base is a clock enable inside a single clock domain. A static 2-bit source input picks one of four bases:

| Code | Time base |
|---|---|
| 0 | every system clock cycle |
| 1 | pulses from the slow-oscillator enable |
| 2 | pulses from the clock-management enable, divided by 16 |
| 3 | none, so the timer is frozen |

The divider is a two-state machine with states ST_COUNT and ST_FIRE:

- **COUNT to FIRE:** taken on a time-base step while the count sits at the last value of the active ratio. The count wraps to zero on that step.
- **FIRE to COUNT:** taken on the next cycle, unless that same cycle is again a final step.
- **Restart:** from either state, an allowed restart forces ST_COUNT.

The tick is high only in ST_FIRE. The active ratio is reloaded only at a wrap or at a restart.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word reads 4'b1111 (restart bit set, select 7, ratio 16384) and the tick is low.
- R2: A write strobe stores the 4-bit data into the control word on that clock edge, whatever the permission input is.
- R3: Select codes 0..7 give ratios 2, 4, 8, 16, 32, 256, 2048, 16384. With source 0 the tick repeats every ratio cycles.
- R4: The tick is high for exactly one cycle per period.
- R5: A write with data bit 3 = 1 and permission = 1 restarts the count and prescaler from zero with the newly written select. The first tick follows exactly ratio time-base steps after the write edge.
- R6: A write with data bit 3 = 0 does not disturb the running count.
- R7: With permission = 0 a write never restarts the count, even with data bit 3 = 1.
- R8: A select change without restart takes effect only at the next wrap. The running period completes with the old ratio, and the next period uses the new one.
- R9: With source 1 the count advances once per cycle in which the slow enable is high. The clock-management enable is ignored.
- R10: With source 2 the count advances once per 16 clock-management enable pulses. The slow enable is ignored. A restart also clears this prescaler.
- R11: With source 3 the count holds and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_sel | input | 2 | time-base select: 0 system, 1 slow enable, 2 clock-management enable / 16, 3 off |
| slow_en | input | 1 | slow-oscillator step pulse |
| cm_en | input | 1 | clock-management step pulse |
| wr_en | input | 1 | control word write strobe |
| wr_data | input | 4 | bit 3 restart request, bits 2:0 ratio select |
| restart_allow | input | 1 | 0 blocks every restart |
| ctrl_q | output | 4 | stored control word |
| tick | output | 1 | one-cycle interval pulse |

## Verification
A write lands in the control word at its own edge, so the stored word is read back at the next falling edge. A restart at edge E0 followed by N steps raises the tick on the falling edge after edge E0+N. The bench timestamps every rising edge and compares tick timestamps against the write timestamp, or against the previous tick, using the bench's own ratio function.

For the pulse-driven sources, the bench counts the enable pulses it issued since the previous tick and expects the ratio, or 16 times the ratio. A pulse driven at a falling edge is consumed at the next rising edge, so a tick seen at a falling edge already includes that pulse.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int SEL_W   = 3;
    localparam int CTRL_W  = SEL_W + 1;
    localparam int TMR_W   = 14;
    localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1111;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_CM   = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_FIRE  = 1'b1
    } div_state_e;

    typedef struct packed {
        logic             restart_mode;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    // Final count value (ratio minus one) for each select code.
    function automatic logic [TMR_W-1:0] last_count(input logic [SEL_W-1:0] sel);
        int unsigned shamt;
        case (sel)
            3'd5:    shamt = 32'd8;
            3'd6:    shamt = 32'd11;
            3'd7:    shamt = 32'd14;
            default: shamt = 32'(sel) + 32'd1;
        endcase
        return TMR_W'((32'd1 << shamt) - 32'd1);
    endfunction

endpackage

// File: rtl/itmr_ctrl_reg.sv
module itmr_ctrl_reg
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              restart_allow,
    output ctrl_t             ctrl,
    output logic              restart_req,
    output logic [SEL_W-1:0]  load_sel
);

    ctrl_t wr_word;

    assign wr_word = ctrl_t'(wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= ctrl_t'(CTRL_RST);
        end else if (wr_en) begin
            ctrl <= wr_word;
        end
    end

    // A restart needs the strobe, the request bit in the new word and permission.
    assign restart_req = wr_en && wr_word.restart_mode && restart_allow;
    assign load_sel    = wr_word.div_sel;

endmodule

// File: rtl/itmr_clk_src.sv
module itmr_clk_src
    import itmr_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       slow_en,
    input  logic       cm_en,
    input  logic       clear,
    output logic       step
);

    src_e src;
    logic cm_step;

    assign src = src_e'(src_sel);

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            logic             cm_sel;

            assign cm_sel = (src == SRC_CM);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clear) begin
                    pre_q <= '0;
                end else if (cm_sel && cm_en) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign cm_step = cm_sel && cm_en && (pre_q == '1);
        end else begin : g_nopre
            logic unused_clr;
            assign unused_clr = clear;
            assign cm_step    = (src == SRC_CM) && cm_en;
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_SYS:  step = 1'b1;
            SRC_SLOW: step = slow_en;
            SRC_CM:   step = cm_step;
            SRC_OFF:  step = 1'b0;
        endcase
    end

endmodule

// File: rtl/itmr_div_fsm.sv
module itmr_div_fsm
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [SEL_W-1:0] load_sel,
    input  logic [SEL_W-1:0] cur_sel,
    output logic             tick
);

    div_state_e       state_q;
    div_state_e       state_d;
    logic [TMR_W-1:0] cnt_q;
    logic [SEL_W-1:0] act_sel_q;
    logic             wrap;

    assign wrap = step && (cnt_q == last_count(act_sel_q));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (restart)   state_d = ST_COUNT;
                else if (wrap) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (restart)   state_d = ST_COUNT;
                else if (wrap) state_d = ST_FIRE;
                else           state_d = ST_COUNT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // Count and active ratio; the ratio is only reloaded at a wrap or restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_sel_q <= CTRL_RST[SEL_W-1:0];
        end else if (restart) begin
            cnt_q     <= '0;
            act_sel_q <= load_sel;
        end else if (wrap) begin
            cnt_q     <= '0;
            act_sel_q <= cur_sel;
        end else if (step) begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tick = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic              slow_en,
    input  logic              cm_en,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              restart_allow,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              tick
);

    localparam int PRE_W = $clog2(PRE_DIV);

    ctrl_t            ctrl;
    logic             restart_req;
    logic [SEL_W-1:0] load_sel;
    logic             step;

    itmr_ctrl_reg u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .restart_allow (restart_allow),
        .ctrl          (ctrl),
        .restart_req   (restart_req),
        .load_sel      (load_sel)
    );

    itmr_clk_src #(.PRE_W(PRE_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .slow_en (slow_en),
        .cm_en   (cm_en),
        .clear   (restart_req),
        .step    (step)
    );

    itmr_div_fsm u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .restart  (restart_req),
        .load_sel (load_sel),
        .cur_sel  (ctrl.div_sel),
        .tick     (tick)
    );

    assign ctrl_q = ctrl;

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  src_sel,
    input logic        wr_en,
    input logic [3:0]  wr_data,
    input logic        restart_allow,
    input logic [3:0]  ctrl_q,
    input logic        tick,
    input logic [13:0] cnt
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == 4'hF && !tick));

    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == $past(wr_data)));

    a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3] && restart_allow) |=> (cnt == 14'd0 && !tick));

    a_r6_plain_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[3] && src_sel == 2'b11) |=> $stable(cnt));

    a_r7_locked_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restart_allow && src_sel == 2'b11) |=> $stable(cnt));

    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b11 && !(wr_en && wr_data[3] && restart_allow)) |=> ($stable(cnt) && !tick));

endmodule

bind interval_timer itmr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_sel       (src_sel),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .restart_allow (restart_allow),
    .ctrl_q        (ctrl_q),
    .tick          (tick),
    .cnt           (u_div.cnt_q)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       slow_en = 1'b0;
    logic       cm_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       restart_allow = 1'b1;
    logic [3:0] ctrl_q;
    logic       tick;

    int unsigned cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    interval_timer u_interval_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_sel       (src_sel),
        .slow_en       (slow_en),
        .cm_en         (cm_en),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .restart_allow (restart_allow),
        .ctrl_q        (ctrl_q),
        .tick          (tick)
    );

    function automatic int exp_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            3'd5: return 256;
            3'd6: return 2048;
            default: return 16384;
        endcase
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] d, input logic allow, output int unsigned t_edge);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        restart_allow = allow;
        @(negedge clk);
        wr_en = 1'b0;
        restart_allow = 1'b1;
        t_edge = cyc;
    endtask

    task automatic wait_tick(input int limit, output int unsigned t);
        t = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (tick) begin
                t = cyc;
                return;
            end
        end
    endtask

    task automatic run_rand(input logic [1:0] src, input logic [2:0] code, input int ntk, input int prob);
        int unsigned t0;
        int pulses;
        int seen;
        int mult;
        string req;
        src_sel = src;
        slow_en = 1'b0;
        cm_en = 1'b0;
        mult = (src == 2'd2) ? 16 : 1;
        req = (src == 2'd2) ? "R10" : "R9";
        do_write({1'b1, code}, 1'b1, t0);
        pulses = 0;
        seen = 0;
        for (int i = 0; i < 60000 && seen < ntk; i++) begin
            @(negedge clk);
            if (tick) begin
                check(req, "pulses per period", pulses, exp_ratio(code) * mult);
                pulses = 0;
                seen++;
            end
            slow_en = ($urandom_range(99) < prob);
            cm_en   = ($urandom_range(99) < prob);
            if ((src == 2'd1 && slow_en) || (src == 2'd2 && cm_en)) pulses++;
        end
        slow_en = 1'b0;
        cm_en = 1'b0;
        check(req, "periods seen", seen, ntk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned t0, t1, t2, tx;
        int n;
        void'($urandom(32'd20250611));

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "ctrl in reset", ctrl_q, 4'hF);
        check("R1", "tick in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ctrl after reset", ctrl_q, 4'hF);
        check("R1", "tick after reset", tick, 0);

        // R3 R4 R5 all codes on system clock
        src_sel = 2'd0;
        for (int c = 0; c < 8; c++) begin
            do_write({1'b1, c[2:0]}, 1'b1, t0);
            check("R2", "ctrl readback", ctrl_q, {1'b1, c[2:0]});
            wait_tick(40000, t1);
            check("R5", "first tick after restart", t1 - t0, exp_ratio(c[2:0]));
            @(negedge clk);
            check("R4", "tick width", tick, 0);
            wait_tick(40000, t2);
            check("R3", "period", t2 - t1, exp_ratio(c[2:0]));
        end

        // R7 restart blocked by permission
        do_write(4'hC, 1'b1, t0);
        repeat (8) @(negedge clk);
        do_write(4'hC, 1'b0, tx);
        check("R2", "ctrl written while locked", ctrl_q, 4'hC);
        wait_tick(100, t1);
        check("R7", "tick unaffected by locked restart", t1 - t0, 32);

        // R6 write without restart bit
        do_write(4'hC, 1'b1, t0);
        repeat (8) @(negedge clk);
        do_write(4'h4, 1'b1, tx);
        check("R2", "ctrl plain write", ctrl_q, 4'h4);
        wait_tick(100, t1);
        check("R6", "count kept running", t1 - t0, 32);

        // R8 select change applies at next wrap
        do_write(4'hC, 1'b1, t0);
        repeat (5) @(negedge clk);
        do_write(4'h2, 1'b1, tx);
        wait_tick(100, t1);
        check("R8", "old ratio completes", t1 - t0, 32);
        wait_tick(100, t2);
        check("R8", "new ratio next", t2 - t1, 8);

        // R11 frozen source
        src_sel = 2'd3;
        do_write(4'h8, 1'b1, t0);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check("R11", "ticks while frozen", n, 0);
        src_sel = 2'd0;
        t0 = cyc;
        wait_tick(20, t1);
        check("R11", "count held at zero", t1 - t0, 2);

        // R9 R10 random pulse sources
        for (int c = 0; c < 4; c++) run_rand(2'd1, c[2:0], 3, 20 + 20 * c);
        for (int c = 0; c < 3; c++) begin
            run_rand(2'd2, c[2:0], 2, 40 + 15 * c);
            // leave the prescaler mid-way so the next restart must clear it
            @(negedge clk);
            cm_en = 1'b1;
            repeat (5) @(negedge clk);
            cm_en = 1'b0;
        end
        src_sel = 2'd2;
        cm_en = 1'b1;
        do_write(4'h8, 1'b1, t0);
        wait_tick(200, t1);
        check("R10", "prescaler cleared by restart", t1 - t0, 32);
        cm_en = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule